// File: doc/BRIEF.md
# Flash Interrupt and Status Controller

This block holds the interrupt status word, the sticky error flags of the controller status word and two system configuration words for a flash interface. It drives an interrupt pin and a ready pin. A command engine tells it, one cycle at a time, that an operation has finished and whether it failed, or that a command code was not recognised. Software reads the four registers through a small register port. It clears interrupt bits by writing a mask that is ANDed into the stored word.

When the master interrupt bit is cleared, the error flags are wiped as well. The polarity of the interrupt pin is chosen by one configuration bit. The ready pin copies another configuration bit. Cold and warm reset requests put the registers back to their reset values, and each kind of reset leaves its own marker in the interrupt word. The flash array and command decoding are handled elsewhere.

Register addresses on `regAddr`: 0 is interrupt status, 1 is controller status (read-only), 2 is configuration word one, 3 is configuration word two.

Top module: `flash_irq_top`

## Requirements
- R1: After `rstN` is deasserted, with no other activity, the registers read as follows: interrupt status 0x8080, controller status 0x0000, configuration one 0x40C0, configuration two 0x0000. `ready` is 1 and `irq` is 1.
- R2: A warm reset request (`warmRst`=1, `coldRst`=0) sets interrupt status to 0x8010 on the next edge, restores configuration one to 0x40C0 and configuration two to 0x0000, clears every error flag and drives `ready` to 1.
- R3: An operation completion (`opDone`=1) sets interrupt bit 15. It also sets bit 7 for `opKind`=0 (load), bit 6 for `opKind`=1 (program) and bit 5 for `opKind`=2 (erase). For `opKind`=3 (other) it sets bit 15 alone.
- R4: A completion with `opFail`=1 sets controller status bit 10 (command error). It also sets bit 13 for a load, bit 12 for a program and bit 11 for an erase. For kind 3 it sets bit 10 alone.
- R5: `badCmd`=1 sets controller status bit 10 and interrupt bit 15.
- R6: A write to address 0 replaces the interrupt status with the bitwise AND of the stored value and `wrData`.
- R7: If bit 15 of that AND result is 0, controller status bits 13:10 all become 0. If bit 15 stays 1, the error flags keep their values.
- R8: `irq` equals interrupt bit 15 XOR the inverse of configuration one bit 6. It reflects every register change on the cycle after that change.
- R9: `ready` takes the value of `wrData` bit 7 on each write to configuration one.
- R10: Reads of configuration one return the stored value with bits 4:0 forced to 0. Configuration two reads back exactly as written.
- R11: When an event and an interrupt-register write happen in the same cycle, the bits set by the event survive in both the interrupt and the controller status words.
- R12: A cold reset request (`coldRst`=1) sets interrupt status to 0x8080 and has priority over a simultaneous warm request, event or register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset, treated as a cold reset |
| coldRst | input | 1 | Synchronous cold reset request |
| warmRst | input | 1 | Synchronous warm reset request |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select for reads and writes |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for `regAddr` (combinational) |
| opDone | input | 1 | Operation finished this cycle |
| opKind | input | 2 | Kind of finished operation: 0 load, 1 program, 2 erase, 3 other |
| opFail | input | 1 | Finished operation failed |
| badCmd | input | 1 | Unrecognised command code seen this cycle |
| irq | output | 1 | Interrupt pin, polarity set by configuration one bit 6 |
| ready | output | 1 | Ready pin |

## Verification
The hardest case to reach is a failing event that lands in the very cycle software clears the master bit. The clear wipes the error flags and the event sets them again. Random traffic rarely lines these up with the right mask, so a directed sequence first leaves erase errors pending. It then issues a zero-mask write to the interrupt register together with a failed load, and checks that only the load error pair remains. A long random phase then mixes writes, events and both kinds of reset request against a behavioural model on every cycle.

// File: rtl/flash_irq_pkg.sv
package flash_irq_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 2;
  localparam int KIND_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_INT  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CFG1 = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_CFG2 = 2'd3;

  localparam int MASTER_BIT     = 15;
  localparam int RST_DONE_BIT   = 4;
  localparam int ERASE_DONE_BIT = 5;
  localparam int PROG_DONE_BIT  = 6;
  localparam int LOAD_DONE_BIT  = 7;

  localparam int ERR_CMD_BIT   = 10;
  localparam int ERR_ERASE_BIT = 11;
  localparam int ERR_PROG_BIT  = 12;
  localparam int ERR_LOAD_BIT  = 13;

  localparam int POL_BIT = 6;
  localparam int RDY_BIT = 7;

  localparam logic [DATA_W-1:0] CFG1_RD_MASK = 16'hFFE0;
  localparam logic [DATA_W-1:0] CFG1_RST     = 16'h40C0;
  localparam logic [DATA_W-1:0] CFG2_RST     = 16'h0000;
  localparam logic [DATA_W-1:0] INT_COLD     = 16'h0001 << MASTER_BIT | 16'h0001 << LOAD_DONE_BIT;
  localparam logic [DATA_W-1:0] INT_WARM     = 16'h0001 << MASTER_BIT | 16'h0001 << RST_DONE_BIT;
  localparam logic [DATA_W-1:0] ERR_MASK     = 16'h3C00;

  typedef enum logic [KIND_W-1:0] {
    OP_LOAD  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_OTHER = 2'd3
  } opKind_e;

  typedef struct packed {
    logic              rstReq;
    logic              rstCold;
    logic              wrInt;
    logic              wrCfg1;
    logic              wrCfg2;
    logic [DATA_W-1:0] intSet;
    logic [DATA_W-1:0] errSet;
  } ctrlStrobe_t;
endpackage

// File: rtl/flash_irq_ctrl.sv
module flash_irq_ctrl
  import flash_irq_pkg::*;
(
  input  logic              coldRst,
  input  logic              warmRst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              opDone,
  input  logic [KIND_W-1:0] opKind,
  input  logic              opFail,
  input  logic              badCmd,
  output ctrlStrobe_t       strb
);
  opKind_e kind;
  logic [DATA_W-1:0] doneBits;
  logic [DATA_W-1:0] failBits;

  assign kind = opKind_e'(opKind);

  // Per-kind completion and error bits (R3, R4)
  always_comb begin
    doneBits = '0;
    failBits = '0;
    doneBits[MASTER_BIT]  = 1'b1;
    failBits[ERR_CMD_BIT] = 1'b1;
    unique case (kind)
      OP_LOAD: begin
        doneBits[LOAD_DONE_BIT] = 1'b1;
        failBits[ERR_LOAD_BIT]  = 1'b1;
      end
      OP_PROG: begin
        doneBits[PROG_DONE_BIT] = 1'b1;
        failBits[ERR_PROG_BIT]  = 1'b1;
      end
      OP_ERASE: begin
        doneBits[ERASE_DONE_BIT] = 1'b1;
        failBits[ERR_ERASE_BIT]  = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    strb         = '0;
    strb.rstReq  = coldRst | warmRst;
    strb.rstCold = coldRst;   // cold wins over warm (R12)
    strb.wrInt   = wrEn && (regAddr == ADDR_INT);
    strb.wrCfg1  = wrEn && (regAddr == ADDR_CFG1);
    strb.wrCfg2  = wrEn && (regAddr == ADDR_CFG2);
    if (opDone) begin
      strb.intSet = strb.intSet | doneBits;
      if (opFail) strb.errSet = strb.errSet | failBits;
    end
    if (badCmd) begin             // unknown command (R5)
      strb.intSet[MASTER_BIT]  = 1'b1;
      strb.errSet[ERR_CMD_BIT] = 1'b1;
    end
  end
endmodule

// File: rtl/flash_irq_dp.sv
module flash_irq_dp
  import flash_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] intStat,
  output logic [DATA_W-1:0] errStat,
  output logic [DATA_W-1:0] cfg1,
  output logic              irq,
  output logic              ready
);
  logic [DATA_W-1:0] intQ, errQ, cfg1Q, cfg2Q;
  logic [DATA_W-1:0] intAnd, errKeep, intD, errD;
  logic readyQ;

  // Clear first, then events on top so they win (R6, R7, R11)
  always_comb begin
    intAnd  = strb.wrInt ? (intQ & wrData) : intQ;
    errKeep = (strb.wrInt && !intAnd[MASTER_BIT]) ? '0 : errQ;
    intD    = intAnd | strb.intSet;
    errD    = (errKeep | strb.errSet) & ERR_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intQ   <= INT_COLD;
      errQ   <= '0;
      cfg1Q  <= CFG1_RST;
      cfg2Q  <= CFG2_RST;
      readyQ <= 1'b1;
    end else if (strb.rstReq) begin
      intQ   <= strb.rstCold ? INT_COLD : INT_WARM;   // R2, R12
      errQ   <= '0;
      cfg1Q  <= CFG1_RST;
      cfg2Q  <= CFG2_RST;
      readyQ <= 1'b1;
    end else begin
      intQ <= intD;
      errQ <= errD;
      if (strb.wrCfg1) begin
        cfg1Q  <= wrData;
        readyQ <= wrData[RDY_BIT];                   // R9
      end
      if (strb.wrCfg2) cfg2Q <= wrData;
    end
  end

  always_comb begin
    unique case (regAddr)
      ADDR_INT:  rdData = intQ;
      ADDR_STAT: rdData = errQ;
      ADDR_CFG1: rdData = cfg1Q & CFG1_RD_MASK;      // R10
      default:   rdData = cfg2Q;
    endcase
  end

  assign irq     = intQ[MASTER_BIT] ^ ~cfg1Q[POL_BIT];  // R8
  assign ready   = readyQ;
  assign intStat = intQ;
  assign errStat = errQ;
  assign cfg1    = cfg1Q;
endmodule

// File: rtl/flash_irq_top.sv
module flash_irq_top
  import flash_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        coldRst,
  input  logic        warmRst,
  input  logic        wrEn,
  input  logic [1:0]  regAddr,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  input  logic        opDone,
  input  logic [1:0]  opKind,
  input  logic        opFail,
  input  logic        badCmd,
  output logic        irq,
  output logic        ready
);
  ctrlStrobe_t strb;
  logic [DATA_W-1:0] intStat, errStat, cfg1;

  flash_irq_ctrl u_ctrl (
    .coldRst(coldRst), .warmRst(warmRst), .wrEn(wrEn), .regAddr(regAddr),
    .opDone(opDone), .opKind(opKind), .opFail(opFail), .badCmd(badCmd),
    .strb(strb)
  );

  flash_irq_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .intStat(intStat), .errStat(errStat), .cfg1(cfg1),
    .irq(irq), .ready(ready)
  );
endmodule

// File: rtl/flash_irq_chk.sv
module flash_irq_chk
  import flash_irq_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              coldRst,
  input logic              warmRst,
  input logic              wrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              opDone,
  input logic              opFail,
  input logic              badCmd,
  input logic              ready,
  input logic [DATA_W-1:0] intStat,
  input logic [DATA_W-1:0] errStat
);
  logic noRst;
  assign noRst = !coldRst && !warmRst;

  p_event_master_r3: assert property (@(posedge clk) disable iff (!rstN)
    (opDone && noRst) |=> intStat[MASTER_BIT]);

  p_fail_cmd_err_r4: assert property (@(posedge clk) disable iff (!rstN)
    (opDone && opFail && noRst) |=> errStat[ERR_CMD_BIT]);

  p_bad_cmd_r5: assert property (@(posedge clk) disable iff (!rstN)
    (badCmd && noRst) |=> (errStat[ERR_CMD_BIT] && intStat[MASTER_BIT]));

  p_and_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == ADDR_INT && !opDone && !badCmd && noRst)
    |=> intStat == ($past(intStat) & $past(wrData)));

  p_err_wipe_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == ADDR_INT && !wrData[MASTER_BIT] && !opDone && !badCmd && noRst)
    |=> errStat == '0);

  p_ready_follow_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == ADDR_CFG1 && noRst) |=> ready == $past(wrData[RDY_BIT]));

  p_warm_value_r2: assert property (@(posedge clk) disable iff (!rstN)
    (warmRst && !coldRst) |=> (intStat == INT_WARM && errStat == '0 && ready));

  p_cold_wins_r12: assert property (@(posedge clk) disable iff (!rstN)
    coldRst |=> intStat == INT_COLD);
endmodule

bind flash_irq_top flash_irq_chk u_chk (
  .clk(clk), .rstN(rstN), .coldRst(coldRst), .warmRst(warmRst), .wrEn(wrEn),
  .regAddr(regAddr), .wrData(wrData), .opDone(opDone), .opFail(opFail),
  .badCmd(badCmd), .ready(ready), .intStat(intStat), .errStat(errStat)
);

// File: tb/flash_irq_top_tb.sv
`timescale 1ns/1ps
module flash_irq_top_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic coldRst = 0, warmRst = 0, wrEn = 0, opDone = 0, opFail = 0, badCmd = 0;
  logic [1:0] regAddr = 0, opKind = 0;
  logic [15:0] wrData = 0;
  logic [15:0] rdData;
  logic irq, ready;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // behavioural reference state
  logic [15:0] mInt, mErr, mCfg1, mCfg2;
  bit mValid = 0;

  always #2.5 clk = ~clk;

  flash_irq_top u_dut (
    .clk(clk), .rstN(rstN), .coldRst(coldRst), .warmRst(warmRst), .wrEn(wrEn),
    .regAddr(regAddr), .wrData(wrData), .rdData(rdData), .opDone(opDone),
    .opKind(opKind), .opFail(opFail), .badCmd(badCmd), .irq(irq), .ready(ready)
  );

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, got, exp, $time);
    end
  endtask

  // Reference model: resets, AND-clear, then events on top
  always @(posedge clk) begin
    logic [15:0] t, e;
    if (!rstN || coldRst) begin
      mInt = 16'h8080; mErr = 0; mCfg1 = 16'h40C0; mCfg2 = 0; mValid = 1;
    end else if (warmRst) begin
      mInt = 16'h8010; mErr = 0; mCfg1 = 16'h40C0; mCfg2 = 0;
    end else begin
      t = mInt; e = mErr;
      if (wrEn && regAddr == 2'd0) begin
        t = t & wrData;
        if (!t[15]) e = 0;
      end
      if (wrEn && regAddr == 2'd2) mCfg1 = wrData;
      if (wrEn && regAddr == 2'd3) mCfg2 = wrData;
      if (opDone) begin
        t[15] = 1;
        case (opKind)
          2'd0: t[7] = 1;
          2'd1: t[6] = 1;
          2'd2: t[5] = 1;
          default: ;
        endcase
        if (opFail) begin
          e[10] = 1;
          case (opKind)
            2'd0: e[13] = 1;
            2'd1: e[12] = 1;
            2'd2: e[11] = 1;
            default: ;
          endcase
        end
      end
      if (badCmd) begin t[15] = 1; e[10] = 1; end
      mInt = t; mErr = e;
    end
  end

  // Compare every cycle, 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (mValid && !done) begin
      chk("R8 irq", {15'd0, irq}, {15'd0, mInt[15] ^ ~mCfg1[6]});
      chk("R9 ready", {15'd0, ready}, {15'd0, mCfg1[7]});
      case (regAddr)
        2'd0: chk("R6 int read", rdData, mInt);
        2'd1: chk("R7 status read", rdData, mErr);
        2'd2: chk("R10 cfg1 read", rdData, mCfg1 & 16'hFFE0);
        default: chk("R10 cfg2 read", rdData, mCfg2);
      endcase
    end
  end

  task automatic idle();
    coldRst = 0; warmRst = 0; wrEn = 0; opDone = 0; opFail = 0; badCmd = 0;
  endtask

  task automatic doWr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); idle(); wrEn = 1; regAddr = a; wrData = d;
    @(negedge clk); idle();
  endtask

  task automatic doOp(logic [1:0] k, logic f);
    @(negedge clk); idle(); opDone = 1; opKind = k; opFail = f;
    @(negedge clk); idle();
  endtask

  task automatic rd(string req, logic [1:0] a, logic [15:0] exp);
    regAddr = a; #0.5;
    chk(req, rdData, exp);
  endtask

  task automatic pins(string req, logic expIrq, logic expRdy);
    chk({req, " irq"}, {15'd0, irq}, {15'd0, expIrq});
    chk({req, " ready"}, {15'd0, ready}, {15'd0, expRdy});
  endtask

  initial begin
    #(200000 * 5);
    miscompares++;
    $display("FAIL R1 watchdog: actual=timeout expected=finish");
    done = 1;
    report();
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset values
    rd("R1 int", 2'd0, 16'h8080);
    rd("R1 stat", 2'd1, 16'h0000);
    rd("R1 cfg1", 2'd2, 16'h40C0);
    rd("R1 cfg2", 2'd3, 16'h0000);
    pins("R1", 1'b1, 1'b1);

    // R6 / R8: clear all, active-high polarity
    doWr(2'd0, 16'h0000);
    rd("R6 clear", 2'd0, 16'h0000);
    pins("R8 low", 1'b0, 1'b1);

    // R3 completion bits
    doOp(2'd0, 0); rd("R3 load", 2'd0, 16'h8080);
    doOp(2'd1, 0); rd("R3 prog", 2'd0, 16'h80C0);
    doOp(2'd2, 0); rd("R3 erase", 2'd0, 16'h80E0);
    doOp(2'd3, 0); rd("R3 other", 2'd0, 16'h80E0);
    doWr(2'd0, 16'h0000);

    // R4 error pairs, R7 wipe and keep
    doOp(2'd0, 1); rd("R4 load fail", 2'd1, 16'h2400);
    doWr(2'd0, 16'h7FFF);
    rd("R7 wipe int", 2'd0, 16'h0080);
    rd("R7 wipe stat", 2'd1, 16'h0000);
    doOp(2'd1, 1); rd("R4 prog fail", 2'd1, 16'h1400);
    doWr(2'd0, 16'h80FF);
    rd("R7 keep int", 2'd0, 16'h80C0);
    rd("R7 keep stat", 2'd1, 16'h1400);
    doWr(2'd0, 16'h0000);
    doOp(2'd2, 1); rd("R4 erase fail", 2'd1, 16'h0C00);
    doWr(2'd0, 16'h0000);
    doOp(2'd3, 1); rd("R4 other fail", 2'd1, 16'h0400);
    doWr(2'd0, 16'h0000);

    // R5 unknown command
    @(negedge clk); idle(); badCmd = 1;
    @(negedge clk); idle();
    rd("R5 int", 2'd0, 16'h8000);
    rd("R5 stat", 2'd1, 16'h0400);
    doWr(2'd0, 16'h0000);

    // R11 event beats a simultaneous clear
    doOp(2'd2, 1);
    @(negedge clk); idle();
    wrEn = 1; regAddr = 2'd0; wrData = 16'h0000; opDone = 1; opKind = 2'd0; opFail = 1;
    @(negedge clk); idle();
    rd("R11 int", 2'd0, 16'h8080);
    rd("R11 stat", 2'd1, 16'h2400);

    // R8 / R9 / R10 polarity, ready and read masking
    doWr(2'd2, 16'h0000);
    pins("R9 cfg1=0", 1'b0, 1'b0);
    doWr(2'd0, 16'h0000);
    pins("R8 inverted", 1'b1, 1'b0);
    doWr(2'd2, 16'hFFFF);
    rd("R10 cfg1 mask", 2'd2, 16'hFFE0);
    pins("R9 cfg1=ffff", 1'b0, 1'b1);
    doWr(2'd3, 16'h1234);
    rd("R10 cfg2", 2'd3, 16'h1234);

    // R2 warm reset
    @(negedge clk); idle(); badCmd = 1;
    @(negedge clk); idle(); warmRst = 1;
    @(negedge clk); idle();
    rd("R2 int", 2'd0, 16'h8010);
    rd("R2 stat", 2'd1, 16'h0000);
    rd("R2 cfg1", 2'd2, 16'h40C0);
    rd("R2 cfg2", 2'd3, 16'h0000);
    pins("R2", 1'b1, 1'b1);

    // R12 cold wins over everything
    @(negedge clk); idle();
    coldRst = 1; warmRst = 1; opDone = 1; opKind = 2'd2; badCmd = 1;
    wrEn = 1; regAddr = 2'd0; wrData = 16'h0000;
    @(negedge clk); idle();
    rd("R12 int", 2'd0, 16'h8080);
    rd("R12 stat", 2'd1, 16'h0000);

    // Random mix against the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      idle();
      coldRst = ($urandom % 300) == 0;
      warmRst = ($urandom % 200) == 0;
      wrEn    = ($urandom % 3) == 0;
      regAddr = 2'($urandom);
      wrData  = 16'($urandom);
      if (($urandom % 2) == 0) wrData[15] = 1'b0;
      opDone  = ($urandom % 4) == 0;
      opKind  = 2'($urandom);
      opFail  = ($urandom % 3) == 0;
      badCmd  = ($urandom % 10) == 0;
    end
    @(negedge clk); idle();
    repeat (2) @(negedge clk);
    done = 1;
    report();
  end
endmodule